// File: doc/BRIEF.md
# Debug Exception Sequencing Controller

This block sits beside an instruction pipeline. It decides, once per instruction boundary, whether a debug exception is raised and of which kind. A separate address matcher supplies per-slot hits: execute hits for the instruction about to run, and data or I/O hits for the accesses it makes. The pipeline supplies a few facts about the instruction: it touches the debug registers, it is a software interrupt, it pops the flags, or it is an interrupt return. From these the controller sorts the event into a fault or a trap. A fault is taken before the instruction takes effect. A trap is taken after the instruction has completed. The controller then sets the sticky status bits and raises a one-cycle exception request that carries a cause code.

The controller also owns three control bits. The trap flag drives single-step. The resume flag masks execute hits for a single instruction. The general-detect enable guards access to the debug registers. It updates each bit on handler entry and when the interrupted code resumes, so that a handler that returns with the resume flag set does not hit the same execute breakpoint again.

Top module: `dbgx_seq_ctrl`

## Requirements
- R1: After reset, exc_req is 0, every status bit is 0, and tf, rf and gd_en are all 0.
- R2: On an instruction beat (ins_vld=1) with rf=0 and a nonzero exec_hit, a fault with cause code 0 is raised, and the exec_hit bits are ORed into bp_status. The instruction does not take effect: its data hits, flag pop, interrupt return and software-interrupt effects are all dropped.
- R3: If an instruction completes with a nonzero data_hit, a trap with cause code 2 is raised, and the data_hit bits are ORed into bp_status.
- R4: While rf=1, execute hits are ignored for one instruction and set no status. rf clears when that instruction completes. rf stays set if the instruction faults.
- R5: If tf=1 at the start of an instruction that completes and is not a software interrupt, a single-step trap with cause code 3 is raised, and bs_status is set.
- R6: If a data hit and a single step occur on the same instruction, exactly one exception is raised, with cause code 2, and both the bp_status bits and bs_status are set.
- R7: If gd_en=1 and the instruction beat has dr_access=1, a general-detect fault with cause code 1 is raised. It takes priority over every other event, sets bd_status and clears gd_en. The clear wins over a gd_wr in the same cycle.
- R8: Every raised exception leaves tf=0. A completed software interrupt (is_swint) clears tf and raises no single-step exception.
- R9: A completed interrupt return loads tf and rf from saved_tf and saved_rf. A completed flag pop loads tf from pop_tf and does not load rf.
- R10: exc_req and exc_cause are registered. exc_req is 1 in the cycle after an instruction beat that raises an exception, and 0 after any cycle without an instruction beat.
- R11: The status bits are sticky until status_clr. Bits set by an event in the same cycle as status_clr remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | One instruction reaches its boundary this cycle |
| exec_hit | input | NBP | Execute-breakpoint matches for this instruction |
| data_hit | input | NBP | Data/I/O breakpoint matches of this instruction's accesses |
| dr_access | input | 1 | Instruction accesses the debug registers |
| is_swint | input | 1 | Instruction is a software interrupt |
| is_pop | input | 1 | Instruction pops the flags |
| pop_tf | input | 1 | Trap flag value carried by the pop |
| is_iret | input | 1 | Instruction is an interrupt return |
| saved_tf | input | 1 | Trap flag from the saved frame |
| saved_rf | input | 1 | Resume flag from the saved frame |
| gd_wr | input | 1 | Write strobe for the general-detect enable |
| gd_wdata | input | 1 | Value written to the general-detect enable |
| status_clr | input | 1 | Clears all status bits |
| exc_req | output | 1 | Exception request pulse |
| exc_cause | output | 2 | 0 fault-bp, 1 general-detect, 2 trap-bp, 3 single-step |
| bp_status | output | NBP | Sticky per-slot breakpoint hit bits |
| bd_status | output | 1 | Sticky debug-register access detected |
| bs_status | output | 1 | Sticky single-step detected |
| tf | output | 1 | Trap flag |
| rf | output | 1 | Resume flag |
| gd_en | output | 1 | General-detect enable |

## Verification
The bench uses the default of four breakpoint slots. With four slots, random hit masks can fall on one slot, on several slots, or on slots that differ between the execute and data inputs, so the OR-accumulation into bp_status is exercised well. The random stream interleaves pops, interrupt returns and general-detect writes. This drives the resume and trap flags through the states where suppression, single-step and trap merging interact. Directed sequences cover the one-instruction window of the resume flag and the priority of general-detect over a simultaneous execute hit.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

    typedef enum logic [1:0] {
        CAUSE_FAULT_BP = 2'd0,
        CAUSE_GEN_DET  = 2'd1,
        CAUSE_TRAP_BP  = 2'd2,
        CAUSE_STEP     = 2'd3
    } cause_e;

endpackage

// File: rtl/dbgx_classify.sv
module dbgx_classify
    import dbgx_pkg::*;
#(
    parameter int NBP = 4
) (
    input  logic           ins_vld,
    input  logic [NBP-1:0] exec_hit,
    input  logic [NBP-1:0] data_hit,
    input  logic           dr_access,
    input  logic           is_swint,
    input  logic           gd_q,
    input  logic           rf_q,
    input  logic           tf_q,
    output logic           take_gd,
    output logic           take_fbp,
    output logic           done,
    output logic           trap_bp,
    output logic           trap_step,
    output logic           raise,
    output cause_e         cause
);

    logic [NBP-1:0] exec_live;

    genvar gi;
    generate
        for (gi = 0; gi < NBP; gi++) begin : g_mask
            assign exec_live[gi] = exec_hit[gi] & ~rf_q;
        end
    endgenerate

    always_comb begin
        take_gd   = ins_vld & gd_q & dr_access;
        take_fbp  = ins_vld & ~take_gd & (|exec_live);
        done      = ins_vld & ~take_gd & ~take_fbp;
        trap_bp   = done & (|data_hit);
        trap_step = done & tf_q & ~is_swint;
        raise     = take_gd | take_fbp | trap_bp | trap_step;
        if (take_gd)       cause = CAUSE_GEN_DET;
        else if (take_fbp) cause = CAUSE_FAULT_BP;
        else if (trap_bp)  cause = CAUSE_TRAP_BP;
        else               cause = CAUSE_STEP;
    end

endmodule

// File: rtl/dbgx_status_upd.sv
module dbgx_status_upd #(
    parameter int NBP = 4
) (
    input  logic           status_clr,
    input  logic [NBP-1:0] bp_q,
    input  logic           bd_q,
    input  logic           bs_q,
    input  logic           take_fbp,
    input  logic           take_gd,
    input  logic           trap_bp,
    input  logic           trap_step,
    input  logic [NBP-1:0] exec_hit,
    input  logic [NBP-1:0] data_hit,
    output logic [NBP-1:0] bp_d,
    output logic           bd_d,
    output logic           bs_d
);

    genvar gi;
    generate
        for (gi = 0; gi < NBP; gi++) begin : g_bit
            assign bp_d[gi] = (bp_q[gi] & ~status_clr)
                            | (take_fbp & exec_hit[gi])
                            | (trap_bp & data_hit[gi]);
        end
    endgenerate

    assign bd_d = (bd_q & ~status_clr) | take_gd;
    assign bs_d = (bs_q & ~status_clr) | trap_step;

endmodule

// File: rtl/dbgx_seq_ctrl.sv
module dbgx_seq_ctrl
    import dbgx_pkg::*;
#(
    parameter int NBP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_vld,
    input  logic [NBP-1:0] exec_hit,
    input  logic [NBP-1:0] data_hit,
    input  logic           dr_access,
    input  logic           is_swint,
    input  logic           is_pop,
    input  logic           pop_tf,
    input  logic           is_iret,
    input  logic           saved_tf,
    input  logic           saved_rf,
    input  logic           gd_wr,
    input  logic           gd_wdata,
    input  logic           status_clr,
    output logic           exc_req,
    output logic [1:0]     exc_cause,
    output logic [NBP-1:0] bp_status,
    output logic           bd_status,
    output logic           bs_status,
    output logic           tf,
    output logic           rf,
    output logic           gd_en
);

    typedef struct packed {
        logic           req;
        cause_e         cause;
        logic [NBP-1:0] bp;
        logic           bd;
        logic           bs;
        logic           tf;
        logic           rf;
        logic           gd;
    } state_t;

    state_t st_d, st_q;

    logic           take_gd, take_fbp, done, trap_bp, trap_step, raise;
    cause_e         cause;
    logic [NBP-1:0] bp_n;
    logic           bd_n, bs_n;

    dbgx_classify #(.NBP(NBP)) u_classify (
        .ins_vld   (ins_vld),
        .exec_hit  (exec_hit),
        .data_hit  (data_hit),
        .dr_access (dr_access),
        .is_swint  (is_swint),
        .gd_q      (st_q.gd),
        .rf_q      (st_q.rf),
        .tf_q      (st_q.tf),
        .take_gd   (take_gd),
        .take_fbp  (take_fbp),
        .done      (done),
        .trap_bp   (trap_bp),
        .trap_step (trap_step),
        .raise     (raise),
        .cause     (cause)
    );

    dbgx_status_upd #(.NBP(NBP)) u_status (
        .status_clr (status_clr),
        .bp_q       (st_q.bp),
        .bd_q       (st_q.bd),
        .bs_q       (st_q.bs),
        .take_fbp   (take_fbp),
        .take_gd    (take_gd),
        .trap_bp    (trap_bp),
        .trap_step  (trap_step),
        .exec_hit   (exec_hit),
        .data_hit   (data_hit),
        .bp_d       (bp_n),
        .bd_d       (bd_n),
        .bs_d       (bs_n)
    );

    always_comb begin
        st_d       = st_q;
        st_d.req   = raise;
        st_d.cause = cause;
        st_d.bp    = bp_n;
        st_d.bd    = bd_n;
        st_d.bs    = bs_n;
        // effects of an instruction that actually completed
        if (done) begin
            if (is_iret) begin
                st_d.tf = saved_tf;
                st_d.rf = saved_rf;
            end else begin
                st_d.rf = 1'b0;
                if (is_pop) st_d.tf = pop_tf;
            end
            if (is_swint) st_d.tf = 1'b0;
        end
        // handler entry drops single-step
        if (raise) st_d.tf = 1'b0;
        if (gd_wr) st_d.gd = gd_wdata;
        if (take_gd) st_d.gd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, cause: CAUSE_FAULT_BP, bp: '0,
                      bd: 1'b0, bs: 1'b0, tf: 1'b0, rf: 1'b0, gd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_req   = st_q.req;
    assign exc_cause = st_q.cause;
    assign bp_status = st_q.bp;
    assign bd_status = st_q.bd;
    assign bs_status = st_q.bs;
    assign tf        = st_q.tf;
    assign rf        = st_q.rf;
    assign gd_en     = st_q.gd;

endmodule

// File: rtl/dbgx_seq_ctrl_chk.sv
module dbgx_seq_ctrl_chk #(
    parameter int NBP = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ins_vld,
    input logic [NBP-1:0] exec_hit,
    input logic           dr_access,
    input logic           is_iret,
    input logic           exc_req,
    input logic [1:0]     exc_cause,
    input logic           bd_status,
    input logic           bs_status,
    input logic           tf,
    input logic           rf,
    input logic           gd_en
);

    AST_REQ_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_vld |=> !exc_req); // R10

    AST_GD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_cause == 2'd1) |-> (!gd_en && bd_status)); // R7

    AST_TF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> !tf); // R8

    AST_STEP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_cause == 2'd3) |-> bs_status); // R5

    AST_RF_MASKS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && rf && !(gd_en && dr_access) && (|exec_hit))
        |=> !(exc_req && exc_cause == 2'd0)); // R4

    AST_RF_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && rf && !(gd_en && dr_access) && !is_iret) |=> !rf); // R4

endmodule

bind dbgx_seq_ctrl dbgx_seq_ctrl_chk #(.NBP(NBP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_vld   (ins_vld),
    .exec_hit  (exec_hit),
    .dr_access (dr_access),
    .is_iret   (is_iret),
    .exc_req   (exc_req),
    .exc_cause (exc_cause),
    .bd_status (bd_status),
    .bs_status (bs_status),
    .tf        (tf),
    .rf        (rf),
    .gd_en     (gd_en)
);

// File: tb/dbgx_seq_ctrl_bench.sv
module dbgx_seq_ctrl_bench;

    localparam int NBP = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic           ins_vld, dr_access, is_swint, is_pop, pop_tf, is_iret;
    logic           saved_tf, saved_rf, gd_wr, gd_wdata, status_clr;
    logic [NBP-1:0] exec_hit, data_hit;
    logic           exc_req, bd_status, bs_status, tf, rf, gd_en;
    logic [1:0]     exc_cause;
    logic [NBP-1:0] bp_status;

    dbgx_seq_ctrl #(.NBP(NBP)) u_dbgx_seq_ctrl (.*);

    int n_run = 0;
    int n_fail = 0;

    // reference state
    logic           m_tf, m_rf, m_gd, m_bd, m_bs, m_req;
    logic [1:0]     m_cause;
    logic [NBP-1:0] m_bp;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tf = 0; m_rf = 0; m_gd = 0; m_bd = 0; m_bs = 0; m_req = 0;
        m_cause = 0; m_bp = '0;
    endtask

    task automatic model_step();
        logic f_gd, f_bp, fin, t_bp, t_st;
        logic [NBP-1:0] eh;
        eh   = m_rf ? '0 : exec_hit;
        f_gd = ins_vld & m_gd & dr_access;
        f_bp = ins_vld & !f_gd & (|eh);
        fin  = ins_vld & !f_gd & !f_bp;
        t_bp = fin & (|data_hit);
        t_st = fin & m_tf & !is_swint;
        if (status_clr) begin m_bp = '0; m_bd = 0; m_bs = 0; end
        if (f_bp) m_bp |= eh;
        if (t_bp) m_bp |= data_hit;
        if (f_gd) m_bd = 1;
        if (t_st) m_bs = 1;
        m_req   = f_gd | f_bp | t_bp | t_st;
        m_cause = f_gd ? 2'd1 : f_bp ? 2'd0 : t_bp ? 2'd2 : 2'd3;
        if (fin) begin
            if (is_iret) begin m_tf = saved_tf; m_rf = saved_rf; end
            else begin m_rf = 0; if (is_pop) m_tf = pop_tf; end
            if (is_swint) m_tf = 0;
        end
        if (m_req) m_tf = 0;
        if (gd_wr) m_gd = gd_wdata;
        if (f_gd) m_gd = 0;
    endtask

    task automatic idle_inputs();
        ins_vld = 0; exec_hit = '0; data_hit = '0; dr_access = 0; is_swint = 0;
        is_pop = 0; pop_tf = 0; is_iret = 0; saved_tf = 0; saved_rf = 0;
        gd_wr = 0; gd_wdata = 0; status_clr = 0;
    endtask

    // inputs are set at a negedge; advance one edge and compare everything
    task automatic cycle(input string rq);
        model_step();
        @(posedge clk);
        #1;
        chk(rq, "exc_req", 32'(exc_req), 32'(m_req));
        if (m_req) chk(rq, "exc_cause", 32'(exc_cause), 32'(m_cause));
        chk(rq, "bp_status", 32'(bp_status), 32'(m_bp));
        chk(rq, "bd/bs", {30'd0, bd_status, bs_status}, {30'd0, m_bd, m_bs});
        chk(rq, "tf/rf/gd", {29'd0, tf, rf, gd_en}, {29'd0, m_tf, m_rf, m_gd});
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle_inputs();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "exc_req", 32'(exc_req), 0);
        chk("R1", "status", {27'd0, bp_status, bd_status, bs_status}, 0);
        chk("R1", "flags", {29'd0, tf, rf, gd_en}, 0);
        rst_n = 1;

        // R2: execute fault drops the pop and the data hit
        ins_vld = 1; exec_hit = 4'b0001; data_hit = 4'b1000; is_pop = 1; pop_tf = 1;
        cycle("R2");
        chk("R2", "cause fault-bp", 32'(exc_cause), 0);
        chk("R2", "bp_status", 32'(bp_status), 32'h1);
        chk("R2", "tf not popped", 32'(tf), 0);
        cycle("R10");
        chk("R10", "pulse drops", 32'(exc_req), 0);

        // R11: clear with a simultaneous new hit keeps the new bit
        status_clr = 1; ins_vld = 1; data_hit = 4'b0100;
        cycle("R11");
        chk("R11", "bp after clr+hit", 32'(bp_status), 32'h4);
        chk("R3", "cause trap-bp", 32'(exc_cause), 2);
        status_clr = 1;
        cycle("R11");
        chk("R11", "bp cleared", 32'(bp_status), 0);

        // R9 / R4: iret sets rf; the next execute hit is masked once
        ins_vld = 1; is_iret = 1; saved_rf = 1; saved_tf = 0;
        cycle("R9");
        chk("R9", "rf from iret", 32'(rf), 1);
        ins_vld = 1; exec_hit = 4'b0010;
        cycle("R4");
        chk("R4", "masked hit", 32'(exc_req), 0);
        chk("R4", "rf cleared", 32'(rf), 0);
        chk("R4", "no status", 32'(bp_status), 0);
        ins_vld = 1; exec_hit = 4'b0010;
        cycle("R4");
        chk("R4", "hit after window", 32'(exc_req), 1);

        // R4: a fault while rf=1 keeps rf
        ins_vld = 1; is_iret = 1; saved_rf = 1;
        cycle("R4");
        gd_wr = 1; gd_wdata = 1;
        cycle("R7");
        ins_vld = 1; dr_access = 1; exec_hit = 4'b1000;
        cycle("R7");
        chk("R7", "cause gd", 32'(exc_cause), 1);
        chk("R7", "gd cleared", 32'(gd_en), 0);
        chk("R7", "bd set", 32'(bd_status), 1);
        chk("R4", "rf kept on fault", 32'(rf), 1);
        ins_vld = 1;
        cycle("R4");

        // R9 / R5 / R8: pop sets tf only, then single step
        ins_vld = 1; is_pop = 1; pop_tf = 1;
        cycle("R9");
        chk("R9", "tf popped", 32'(tf), 1);
        chk("R9", "rf untouched", 32'(rf), 0);
        ins_vld = 1;
        cycle("R5");
        chk("R5", "cause step", 32'(exc_cause), 3);
        chk("R5", "bs", 32'(bs_status), 1);
        chk("R8", "tf dropped", 32'(tf), 0);

        // R6: step + data hit merged
        status_clr = 1; ins_vld = 1; is_pop = 1; pop_tf = 1;
        cycle("R6");
        ins_vld = 1; data_hit = 4'b0110;
        cycle("R6");
        chk("R6", "cause trap-bp", 32'(exc_cause), 2);
        chk("R6", "bp", 32'(bp_status), 32'h6);
        chk("R6", "bs", 32'(bs_status), 1);
        cycle("R10");
        chk("R10", "single pulse", 32'(exc_req), 0);

        // R8: software interrupt clears tf, no step
        ins_vld = 1; is_pop = 1; pop_tf = 1;
        cycle("R8");
        ins_vld = 1; is_swint = 1;
        cycle("R8");
        chk("R8", "swint no exc", 32'(exc_req), 0);
        chk("R8", "swint tf", 32'(tf), 0);

        // random stream
        for (int i = 0; i < 4000; i++) begin
            ins_vld    = ($urandom % 4) != 0;
            exec_hit   = ($urandom % 6 == 0) ? NBP'($urandom) : '0;
            data_hit   = ($urandom % 5 == 0) ? NBP'($urandom) : '0;
            dr_access  = ($urandom % 6 == 0);
            is_swint   = ($urandom % 12 == 0);
            is_pop     = ($urandom % 6 == 0);
            pop_tf     = 1'($urandom);
            is_iret    = ($urandom % 7 == 0);
            saved_tf   = 1'($urandom);
            saved_rf   = 1'($urandom);
            gd_wr      = ($urandom % 8 == 0);
            gd_wdata   = 1'($urandom);
            status_clr = ($urandom % 10 == 0);
            cycle("R10");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule